// File: doc/BRIEF.md
# B8ZS AMI Line Transmit Encoder

This block turns terminal-side transmit data into positive and negative rail pulse commands for a 1.544 Mbit/s bipolar line. Each output bit is one bit period; a high `line_pos` asks the line driver for a positive pulse, a high `line_neg` for a negative pulse, and both low for a null. It runs on the transmit clock, except for the blue (all-ones alarm) generator, which runs on its own independent blue clock.

In single-rail mode, unipolar data is encoded with alternate mark inversion. When the zero-substitution control is high, every run of eight zeros is replaced by the bipolar-violation code. In dual-rail mode, the two rail inputs pass straight through and the substitution control pin becomes the negative rail. A remote-loopback control sends the recovered receive rails out instead. A blue control overrides every other source and sends alternating marks at the blue clock rate.

Every path through the transmit clock domain has the same latency. All of them go through one eight-entry look-ahead pipeline, which gives the substitution logic sight of a full zero run before the first zero of that run leaves.

Top module: `b8zs_tx_encoder`

## Requirements
- R1: In single-rail mode (`dual_sel`=0, `loop_remote_n`=1), a 1 on `txd_pos` sampled at clock edge k appears as a pulse on the rails after edge k+8, with polarity opposite to the previous encoder-generated pulse; a 0 appears as a null (both rails low).
- R2: A synchronous reset drives both rails low, and the first mark after reset is positive (`line_pos`); the first blue mark after reset is also positive.
- R3: In dual-rail mode (`dual_sel`=1), `txd_pos` high gives a positive pulse and `txd_neg_bzen` high gives a negative pulse, both with the same eight-edge latency; substitution is disabled.
- R4: A dual-rail or loopback input with both rails high is sent as a null.
- R5: In single-rail mode, when eight consecutive zeros all entered with `txd_neg_bzen`=1, they leave as the code 0,0,0,V,B,0,V,B; V has the polarity of the pulse just before it, and B has the opposite polarity (normal alternation).
- R6: After a substituted block, the alternation state is the one left by its final B, so the next mark is opposite to that B.
- R7: Substitution blocks do not overlap: sixteen zeros give two back-to-back codes, and seven zeros give none.
- R8: With `txd_neg_bzen`=0 in single-rail mode, zero runs of any length leave as nulls.
- R9: With `loop_remote_n`=0, the recovered rails `rxr_pos`/`rxr_neg` are transmitted with the eight-edge latency, whatever `dual_sel` says; pass-through pulses do not change the alternation state.
- R10: With `blue_on`=1, the rails carry a mark on every blue clock period with alternating polarity, and this overrides remote loopback.
- R11: `line_pos` and `line_neg` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset (both domains) |
| blue_clk | input | 1 | Independent blue-signal clock |
| blue_on | input | 1 | Transmit blue control, active high |
| dual_sel | input | 1 | 0 = single-rail, 1 = dual-rail |
| txd_pos | input | 1 | Single-rail data, or positive rail in dual-rail |
| txd_neg_bzen | input | 1 | Substitution enable in single-rail, negative rail in dual-rail |
| loop_remote_n | input | 1 | Remote loopback, active low |
| rxr_pos | input | 1 | Recovered receive positive rail |
| rxr_neg | input | 1 | Recovered receive negative rail |
| line_pos | output | 1 | Positive pulse command |
| line_neg | output | 1 | Negative pulse command |

## Verification
The embedded properties watch, on every cycle, that the rails are mutually exclusive and that a non-substituted single-rail zero leaves as a null. They also check that a substitution block, once started, walks through all eight slots without restarting, and that the blue generator alternates on every blue edge. The exact placement and polarity of V and B pulses, the alternation carried across a block, the eight-edge latency, and loopback and dual-rail pass-through depend on input history. Only the bench's reference model can show these, and it compares them bit by bit over directed zero runs, random mark densities, and mode and loopback switches.

// File: rtl/b8zs_pkg.sv
package b8zs_pkg;

  // One look-ahead entry: raw = rail pass-through entry, mark/ben = single-rail bit and its substitution enable
  typedef struct packed {
    logic raw;
    logic mark;
    logic ben;
    logic p;
    logic n;
  } lane_t;

  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_VIOL = 2'd1,
    SYM_BIP  = 2'd2
  } sym_e;

  localparam int unsigned CODE_LEN = 8;

  // Slot symbol of the eight-bit zero-substitution code
  function automatic sym_e code_sym(input logic [2:0] slot);
    case (slot)
      3'd3, 3'd6: code_sym = SYM_VIOL;
      3'd4, 3'd7: code_sym = SYM_BIP;
      default:    code_sym = SYM_NULL;
    endcase
  endfunction

endpackage

// File: rtl/b8zs_lookahead.sv
module b8zs_lookahead
  import b8zs_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  lane_t                 din,
  output lane_t [DEPTH-1:0]     win
);

  lane_t [DEPTH-1:0] stg_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    lane_t nxt;
    if (i == 0) begin : g_head
      assign nxt = din;
    end else begin : g_body
      assign nxt = stg_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst) stg_q[i] <= '0;
      else     stg_q[i] <= nxt;
    end
  end

  assign win = stg_q;

endmodule

// File: rtl/b8zs_ami_core.sv
module b8zs_ami_core
  import b8zs_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  lane_t [DEPTH-1:0] win,
  output logic              out_p,
  output logic              out_n
);

  lane_t         tail;
  logic          all_zero;
  logic          start;
  logic          in_sub;
  logic [SW-1:0] sub_cnt, sub_cnt_d, slot;
  logic          last_pos, last_pos_d;   // 1 = previous generated pulse was positive
  logic          p_d, n_d;
  sym_e          sym;

  assign tail = win[DEPTH-1];

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (win[i].raw || win[i].mark || !win[i].ben) all_zero = 1'b0;
    end
  end

  assign start  = (sub_cnt == '0) && all_zero;
  assign in_sub = start || (sub_cnt != '0);
  assign slot   = start ? '0 : sub_cnt;
  assign sym    = code_sym(3'(slot));

  always_comb begin
    p_d        = 1'b0;
    n_d        = 1'b0;
    last_pos_d = last_pos;
    if (tail.raw) begin
      p_d = tail.p & ~tail.n;
      n_d = tail.n & ~tail.p;
    end else if (in_sub) begin
      if (sym == SYM_VIOL) begin
        p_d = last_pos;
        n_d = ~last_pos;
      end else if (sym == SYM_BIP) begin
        p_d        = ~last_pos;
        n_d        = last_pos;
        last_pos_d = ~last_pos;
      end
    end else if (tail.mark) begin
      p_d        = ~last_pos;
      n_d        = last_pos;
      last_pos_d = ~last_pos;
    end
  end

  assign sub_cnt_d = in_sub ? SW'(slot + 1'b1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt  <= '0;
      last_pos <= 1'b0;
      out_p    <= 1'b0;
      out_n    <= 1'b0;
    end else begin
      sub_cnt  <= sub_cnt_d;
      last_pos <= last_pos_d;
      out_p    <= p_d;
      out_n    <= n_d;
    end
  end

  // R11
  rails_excl_chk: assert property (@(posedge clk) disable iff (rst) !(out_p && out_n));

  // R7
  slot_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_cnt != '0) |=> (sub_cnt == SW'($past(sub_cnt) + 1'b1)));

  // R1
  zero_null_chk: assert property (@(posedge clk) disable iff (rst)
    (!tail.raw && !tail.mark && !in_sub) |=> (!out_p && !out_n));

endmodule

// File: rtl/b8zs_blue_gen.sv
module b8zs_blue_gen (
  input  logic blue_clk,
  input  logic rst,
  output logic blue_p,
  output logic blue_n
);

  logic phase;

  always_ff @(posedge blue_clk) begin
    if (rst) begin
      phase  <= 1'b0;
      blue_p <= 1'b0;
      blue_n <= 1'b0;
    end else begin
      phase  <= ~phase;
      blue_p <= ~phase;
      blue_n <= phase;
    end
  end

  // R10
  blue_alt_pn_chk: assert property (@(posedge blue_clk) disable iff (rst) blue_p |=> blue_n);

  // R10
  blue_alt_np_chk: assert property (@(posedge blue_clk) disable iff (rst) blue_n |=> blue_p);

endmodule

// File: rtl/b8zs_tx_encoder.sv
module b8zs_tx_encoder
  import b8zs_pkg::*;
#(
  parameter int unsigned DEPTH = CODE_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic blue_clk,
  input  logic blue_on,
  input  logic dual_sel,
  input  logic txd_pos,
  input  logic txd_neg_bzen,
  input  logic loop_remote_n,
  input  logic rxr_pos,
  input  logic rxr_neg,
  output logic line_pos,
  output logic line_neg
);

  lane_t              entry;
  lane_t [DEPTH-1:0]  win;
  logic               enc_p, enc_n;
  logic               blu_p, blu_n;

  // Source selection at pipeline entry: loopback, then dual-rail, then single-rail
  always_comb begin
    entry = '0;
    if (!loop_remote_n) begin
      entry.raw = 1'b1;
      entry.p   = rxr_pos;
      entry.n   = rxr_neg;
    end else if (dual_sel) begin
      entry.raw = 1'b1;
      entry.p   = txd_pos;
      entry.n   = txd_neg_bzen;
    end else begin
      entry.mark = txd_pos;
      entry.ben  = txd_neg_bzen;
    end
  end

  b8zs_lookahead #(.DEPTH(DEPTH)) i_look (
    .clk (clk),
    .rst (rst),
    .din (entry),
    .win (win)
  );

  b8zs_ami_core #(.DEPTH(DEPTH)) i_core (
    .clk   (clk),
    .rst   (rst),
    .win   (win),
    .out_p (enc_p),
    .out_n (enc_n)
  );

  b8zs_blue_gen i_blue (
    .blue_clk (blue_clk),
    .rst      (rst),
    .blue_p   (blu_p),
    .blue_n   (blu_n)
  );

  assign line_pos = blue_on ? blu_p : enc_p;
  assign line_neg = blue_on ? blu_n : enc_n;

endmodule

// File: tb/test_b8zs_tx_encoder.sv
`timescale 1ns/1ps
module test_b8zs_tx_encoder;

  logic clk = 1'b0, blue_clk = 1'b0, rst = 1'b1;
  logic blue_on = 1'b0, dual_sel = 1'b0, txd_pos = 1'b0, txd_neg_bzen = 1'b0;
  logic loop_remote_n = 1'b1, rxr_pos = 1'b0, rxr_neg = 1'b0;
  logic line_pos, line_neg;

  int vectors = 0, errors = 0;
  string cur_req = "R2";
  bit chk_en = 0, blue_chk = 0, log_en = 0;
  int obs[$];

  always #4 clk = ~clk;
  always #4.1 blue_clk = ~blue_clk;

  b8zs_tx_encoder i_b8zs_tx_encoder (
    .clk(clk), .rst(rst), .blue_clk(blue_clk), .blue_on(blue_on), .dual_sel(dual_sel),
    .txd_pos(txd_pos), .txd_neg_bzen(txd_neg_bzen), .loop_remote_n(loop_remote_n),
    .rxr_pos(rxr_pos), .rxr_neg(rxr_neg), .line_pos(line_pos), .line_neg(line_neg)
  );

  // Behavioural reference model
  typedef struct { bit raw; bit m; bit ben; bit p; bit n; } ent_t;
  ent_t q[$];
  int sub_pos = -1;
  bit m_last_pos = 0;
  bit ep = 0, en = 0;
  bit ebp = 0, ebn = 0, bph = 0;

  always @(posedge clk) begin
    ent_t e, nw;
    bit allz;
    if (rst) begin
      q.delete();
      for (int i = 0; i < 8; i++) begin
        nw = '{0, 0, 0, 0, 0};
        q.push_back(nw);
      end
      sub_pos = -1; m_last_pos = 0; ep = 0; en = 0;
    end else begin
      allz = 1;
      for (int i = 0; i < 8; i++) if (q[i].raw || q[i].m || !q[i].ben) allz = 0;
      if (sub_pos < 0 && allz) sub_pos = 0;
      e = q.pop_front();
      ep = 0; en = 0;
      if (e.raw) begin
        ep = e.p && !e.n; en = e.n && !e.p;
      end else if (sub_pos >= 0) begin
        if (sub_pos == 3 || sub_pos == 6) begin
          ep = m_last_pos; en = !m_last_pos;
        end else if (sub_pos == 4 || sub_pos == 7) begin
          ep = !m_last_pos; en = m_last_pos; m_last_pos = !m_last_pos;
        end
      end else if (e.m) begin
        ep = !m_last_pos; en = m_last_pos; m_last_pos = !m_last_pos;
      end
      if (sub_pos >= 0) sub_pos = (sub_pos == 7) ? -1 : sub_pos + 1;
      nw = '{0, 0, 0, 0, 0};
      if (!loop_remote_n) begin nw.raw = 1; nw.p = rxr_pos; nw.n = rxr_neg; end
      else if (dual_sel) begin nw.raw = 1; nw.p = txd_pos; nw.n = txd_neg_bzen; end
      else begin nw.m = txd_pos; nw.ben = txd_neg_bzen; end
      q.push_back(nw);
    end
  end

  always @(posedge blue_clk) begin
    if (rst) begin bph = 0; ebp = 0; ebn = 0; end
    else begin ebp = !bph; ebn = bph; bph = !bph; end
  end

  always @(negedge clk) begin
    if (chk_en && !blue_on) begin
      vectors++;
      if ({line_pos, line_neg} !== {ep, en}) begin
        errors++;
        $display("FAIL %s: rails actual %b%b expected %b%b at %0t", cur_req, line_pos, line_neg, ep, en, $time);
      end
    end
    if (log_en) obs.push_back(line_pos ? 1 : (line_neg ? -1 : 0));
  end

  always @(negedge blue_clk) begin
    if (blue_chk) begin
      vectors++;
      if ({line_pos, line_neg} !== {ebp, ebn}) begin
        errors++;
        $display("FAIL R10: blue rails actual %b%b expected %b%b at %0t", line_pos, line_neg, ebp, ebn, $time);
      end
    end
  end

  task automatic step(input bit d, input bit nb);
    @(negedge clk);
    txd_pos = d; txd_neg_bzen = nb;
  endtask

  task automatic zeros(input int cnt, input bit nb);
    for (int i = 0; i < cnt; i++) step(0, nb);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int exp_seq[10] = '{1, 0, 0, 0, 1, -1, 0, -1, 1, -1};
    int first;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    vectors++;
    if (line_pos !== 1'b0 || line_neg !== 1'b0) begin
      errors++;
      $display("FAIL R2: reset rails actual %b%b expected 00", line_pos, line_neg);
    end
    chk_en = 1;
    log_en = 1;
    // R2 R5 R6: 1, eight enabled zeros, 1
    cur_req = "R5";
    step(1, 1);
    zeros(8, 1);
    step(1, 0);
    zeros(14, 0);
    log_en = 0;
    first = -1;
    for (int i = 0; i < obs.size(); i++) if (first < 0 && obs[i] != 0) first = i;
    vectors++;
    if (first < 0 || first + 10 > obs.size()) begin
      errors++;
      $display("FAIL R5: substitution sequence actual missing expected present");
    end else begin
      for (int i = 0; i < 10; i++) begin
        if (obs[first + i] != exp_seq[i]) begin
          errors++;
          $display("FAIL %s: slot %0d actual %0d expected %0d", (i == 0) ? "R2" : (i == 9 ? "R6" : "R5"),
                   i, obs[first + i], exp_seq[i]);
        end
      end
    end
    // R8: random data, substitution off
    cur_req = "R8";
    for (int i = 0; i < 200; i++) step(($urandom % 4) == 0, 0);
    zeros(20, 0);
    // R1: dense random data
    cur_req = "R1";
    for (int i = 0; i < 150; i++) step($urandom % 2, 0);
    // R7: seven zeros, then sixteen zeros, substitution on
    cur_req = "R7";
    step(1, 1); zeros(7, 1); step(1, 1);
    zeros(16, 1); step(1, 1); step(1, 1);
    zeros(24, 1); step(1, 1);
    // R5 R6: sparse random marks with substitution on
    cur_req = "R6";
    for (int i = 0; i < 400; i++) step(($urandom % 7) == 0, 1);
    // R3 R4: dual-rail random including both-high
    cur_req = "R3";
    dual_sel = 1;
    for (int i = 0; i < 200; i++) step($urandom % 2, $urandom % 2);
    cur_req = "R4";
    for (int i = 0; i < 20; i++) step(1, 1);
    zeros(12, 1);
    // R9: loopback overrides both modes
    cur_req = "R9";
    loop_remote_n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rxr_pos = $urandom % 2; rxr_neg = $urandom % 2;
      txd_pos = $urandom % 2; txd_neg_bzen = 1;
      if (i == 100) dual_sel = 0;
    end
    // R10: blue overrides loopback
    cur_req = "R10";
    @(negedge clk);
    blue_on = 1;
    repeat (3) @(negedge clk);
    blue_chk = 1;
    repeat (100) @(negedge clk);
    blue_chk = 0;
    repeat (2) @(negedge clk);
    blue_on = 0;
    // back to single-rail after leaving loopback
    cur_req = "R1";
    @(negedge clk);
    loop_remote_n = 1; rxr_pos = 0; rxr_neg = 0;
    for (int i = 0; i < 80; i++) step(($urandom % 3) == 0, 1);
    zeros(20, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule